// File: doc/BRIEF.md
# Hexadecimal Seven-Segment Driver with Overrides

This block turns a 4-bit nibble into the segment pattern for one hexadecimal digit (0–9, A, b, C, d, E, F) on a single seven-segment display. A nibble arrives on a small valid/ready stream input and is stored in a digit register. The display shows the stored digit until another nibble is accepted.

Two plain control pins override the decoded pattern. A lamp-test pin lights every segment. A blank pin darkens the whole display. A hold pin freezes the stored digit by withdrawing ready. Back-pressure is simple: `in_ready` is the inverse of `hold`, and a nibble is taken only in a cycle where both `in_valid` and `in_ready` are high. A built-in dimmer has a 4-bit free-running phase counter and a 4-bit level. The display is blanked in the counter phases that lie below the level, so the brightness falls as the level rises. Dimming blanks the display in the same way as the blank pin, so it also wins over lamp test.

Top module: `hex7_driver`

## Requirements
- R1: While `rst_n` is low and just after it is released, the digit register holds 0 and the phase counter holds 0. With no override active, `seg` then shows the glyph for 0 (7'h7E).
- R2: `seg[6]` drives segment a, and the bits go down in order to `seg[0]`, which drives segment g. Segments are active-high. The glyphs for digits 0 to F are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B, 77, 1F, 4E, 3D, 4F, 47 (hex). Letters b and d are lowercase, and A, C, E and F are uppercase.
- R3: With `lamp_test` high and no blanking active, `seg` is 7'h7F whatever digit is stored.
- R4: With `blank_in` high, `seg` is 7'h00 whatever `lamp_test` and the stored digit are.
- R5: `in_ready` equals the inverse of `hold`. A nibble is stored at a clock edge where `in_valid` and `in_ready` are both high, and it shows on `seg` right after that edge.
- R6: While `hold` is high, nibbles offered on the input do not change the displayed digit. Once `hold` falls, the next valid nibble is accepted.
- R7: A clock edge with `in_valid` low leaves the stored digit unchanged.
- R8: The phase counter starts at 0 after reset and advances by one at every clock edge. It wraps modulo 16. The display is blanked in every cycle where the counter is below `dim_level`. A level of 0 never blanks, and over any 16 consecutive cycles exactly `dim_level` cycles are blanked.
- R9: Blanking from the dimmer takes priority over `lamp_test`. With lamp test on and level L, 16 consecutive cycles show L cycles dark and 16−L cycles fully lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Nibble on `in_digit` is valid |
| in_ready | output | 1 | Block can accept a nibble (low while holding) |
| in_digit | input | 4 | Hexadecimal value to display |
| hold | input | 1 | Freeze the stored digit |
| lamp_test | input | 1 | Light all segments |
| blank_in | input | 1 | Darken all segments (highest priority) |
| dim_level | input | 4 | Number of blanked phases out of 16 |
| seg | output | 7 | Segment drive, bit 6 = a … bit 0 = g, active-high |

## Verification
The hardest condition to reach is the relation between the hidden phase counter and the visible blanking. The counter cannot be read or preset, so its phase is pinned down only by sampling directly after reset release, when it is known to be 0. After that point, dimming is judged by counting dark cycles over complete 16-cycle windows. The bench displays a fully lit digit (8) during each window, so that every dark cycle can only come from the dimmer. It repeats the windows with lamp test on to expose the priority.

// File: rtl/hex7_pkg.sv
package hex7_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int DIM_W   = 4;

  typedef logic [SEG_N-1:0] seg_t;

  // bit 6 = segment a ... bit 0 = segment g, active-high
  function automatic seg_t glyph(input logic [DIGIT_W-1:0] v);
    seg_t s;
    unique case (v)
      4'h0: s = 7'h7E;
      4'h1: s = 7'h30;
      4'h2: s = 7'h6D;
      4'h3: s = 7'h79;
      4'h4: s = 7'h33;
      4'h5: s = 7'h5B;
      4'h6: s = 7'h5F;
      4'h7: s = 7'h70;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h7B;
      4'hA: s = 7'h77;
      4'hB: s = 7'h1F;
      4'hC: s = 7'h4E;
      4'hD: s = 7'h3D;
      4'hE: s = 7'h4F;
      default: s = 7'h47;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/hex7_capture.sv
module hex7_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         hold,
  input  logic [W-1:0] in_digit,
  output logic         in_ready,
  output logic [W-1:0] digit_q
);
  logic take;

  assign in_ready = ~hold;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    digit_q <= '0;
    else if (take) digit_q <= in_digit;
  end
endmodule

// File: rtl/hex7_dimmer.sv
module hex7_dimmer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         dim_blank
);
  localparam logic [W-1:0] STEP = 1;
  logic [W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + STEP;
  end

  assign dim_blank = (phase_q < level);
endmodule

// File: rtl/hex7_select.sv
module hex7_select #(
  parameter int N = 7
) (
  input  logic [N-1:0] pattern,
  input  logic         lamp_test,
  input  logic         blank_any,
  output logic [N-1:0] seg
);
  always_comb begin
    if (blank_any)      seg = '0;
    else if (lamp_test) seg = '1;
    else                seg = pattern;
  end
endmodule

// File: rtl/hex7_driver.sv
module hex7_driver
  import hex7_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIGIT_W-1:0] in_digit,
  input  logic               hold,
  input  logic               lamp_test,
  input  logic               blank_in,
  input  logic [DIM_W-1:0]   dim_level,
  output logic [SEG_N-1:0]   seg
);
  logic [DIGIT_W-1:0] digit_q;
  logic               dim_blank;
  seg_t               pattern;

  hex7_capture #(.W(DIGIT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hold(hold),
    .in_digit(in_digit), .in_ready(in_ready), .digit_q(digit_q)
  );

  hex7_dimmer #(.W(DIM_W)) u_dim (
    .clk(clk), .rst_n(rst_n), .level(dim_level), .dim_blank(dim_blank)
  );

  assign pattern = glyph(digit_q);

  hex7_select #(.N(SEG_N)) u_sel (
    .pattern(pattern), .lamp_test(lamp_test),
    .blank_any(blank_in | dim_blank), .seg(seg)
  );
endmodule

// File: rtl/hex7_driver_checks.sv
module hex7_driver_checks
  import hex7_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               hold,
  input logic               lamp_test,
  input logic               blank_in,
  input logic [DIM_W-1:0]   dim_level,
  input logic [SEG_N-1:0]   seg
);
  logic quiet;
  assign quiet = !lamp_test && !blank_in && (dim_level == '0);

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |-> (seg == '0)); // R4

  AST_TEST_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test && !blank_in && dim_level == '0) |-> (seg == '1)); // R3

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !hold); // R5

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && quiet) |=> (!quiet || $stable(seg))); // R6

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && quiet) |=> (!quiet || $stable(seg))); // R7

  AST_NO_DIM_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> (seg != '0)); // R8
endmodule

bind hex7_driver hex7_driver_checks u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .hold(hold), .lamp_test(lamp_test), .blank_in(blank_in),
  .dim_level(dim_level), .seg(seg)
);

// File: tb/hex7_driver_test.sv
module hex7_driver_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [3:0] in_digit = 0;
  logic       hold = 0;
  logic       lamp_test = 0;
  logic       blank_in = 0;
  logic [3:0] dim_level = 0;
  logic [6:0] seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  hex7_driver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_digit(in_digit), .hold(hold), .lamp_test(lamp_test),
    .blank_in(blank_in), .dim_level(dim_level), .seg(seg)
  );

  // {digit[3:0], test, blank, expected seg[6:0]}
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    {4'h0,1'b0,1'b0,7'h7E}, {4'h1,1'b0,1'b0,7'h30}, {4'h2,1'b0,1'b0,7'h6D},
    {4'h3,1'b0,1'b0,7'h79}, {4'h4,1'b0,1'b0,7'h33}, {4'h5,1'b0,1'b0,7'h5B},
    {4'h6,1'b0,1'b0,7'h5F}, {4'h7,1'b0,1'b0,7'h70}, {4'h8,1'b0,1'b0,7'h7F},
    {4'h9,1'b0,1'b0,7'h7B}, {4'hA,1'b0,1'b0,7'h77}, {4'hB,1'b0,1'b0,7'h1F},
    {4'hC,1'b0,1'b0,7'h4E}, {4'hD,1'b0,1'b0,7'h3D}, {4'hE,1'b0,1'b0,7'h4F},
    {4'hF,1'b0,1'b0,7'h47}, {4'h1,1'b1,1'b0,7'h7F}, {4'hC,1'b1,1'b1,7'h00},
    {4'h8,1'b0,1'b1,7'h00}, {4'h0,1'b1,1'b0,7'h7F}
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic load(input logic [3:0] d);
    in_digit = d; in_valid = 1;
    tick();
    in_valid = 0;
  endtask

  task automatic dim_window(input logic [3:0] lvl, input logic tst, input string req);
    int dark = 0;
    int lit  = 0;
    dim_level = lvl; lamp_test = tst;
    for (int c = 0; c < 16; c++) begin
      #5;
      if (seg == 7'h00) dark++;
      if (seg == 7'h7F) lit++;
      tick();
    end
    check(req, 7'(dark), 7'(lvl));
    check(req, 7'(lit), 7'(16 - lvl));
    dim_level = 0; lamp_test = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(); #3;
    check("R1 in reset", seg, 7'h7E);
    rst_n = 1; tick();
    check("R1 after release", seg, 7'h7E);

    // R2/R3/R4 vector walk
    for (int i = 0; i < NV; i++) begin
      lamp_test = VEC[i][8];
      blank_in  = VEC[i][7];
      load(VEC[i][12:9]);
      if (VEC[i][7])      check("R4 blank", seg, VEC[i][6:0]);
      else if (VEC[i][8]) check("R3 test", seg, VEC[i][6:0]);
      else                check("R2 glyph", seg, VEC[i][6:0]);
    end
    lamp_test = 0; blank_in = 0;

    // R5 / R6 / R7: hold and idle behaviour
    load(4'h3);
    check("R5 captured", seg, 7'h79);
    check("R5 ready", {6'd0, in_ready}, 7'd1);
    hold = 1; #1;
    check("R5 not ready", {6'd0, in_ready}, 7'd0);
    load(4'h9);
    check("R6 held", seg, 7'h79);
    hold = 0;
    load(4'h9);
    check("R6 released", seg, 7'h7B);
    in_digit = 4'hA; in_valid = 0;
    tick();
    check("R7 idle", seg, 7'h7B);

    // R8: counter phase right after reset
    rst_n = 0; dim_level = 4'd1; #3;
    rst_n = 1; #1;
    check("R8 phase0 dark", seg, 7'h00);
    tick();
    check("R8 phase1 lit", seg, 7'h7E);
    dim_level = 0;

    // R8 / R9 windows with digit 8 shown
    load(4'h8);
    dim_window(4'd0,  1'b0, "R8 level0");
    dim_window(4'd5,  1'b0, "R8 level5");
    dim_window(4'd12, 1'b0, "R8 level12");
    dim_window(4'd15, 1'b0, "R8 level15");
    load(4'h1);
    dim_window(4'd8,  1'b1, "R9 dim over test");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule